// File: doc/BRIEF.md
# Boot ROM Region Decoder

This block sits on the host side of a legacy ISA-style memory bus and decides which host memory requests belong to the boot ROM or to an optional expansion ROM. Each request carries a 32-bit physical address. The block compares it against a small set of address windows. When a window matches, the block claims the request and runs a timed ISA memory cycle with the right chip select asserted. When no window matches, it stays silent so that another decoder can answer the request.

Two boot windows are always active: the top 64 KB of the first megabyte and the top 256 KB of the 4 GB space. Configuration bits can widen these to 128 KB and 16 MB, and can open a separate expansion-ROM window with its own chip select. A strap pin picks an 8-bit or 16-bit ROM at reset, and software can change that choice later. Writes to ROM are dropped unless software sets a write-enable bit. In 8-bit mode a two-byte host access is split into two byte cycles.

Top module: `boot_rom_decoder`

## Requirements
- R1: After reset, requests to 0x000F0000-0x000FFFFF and 0xFFFC0000-0xFFFFFFFF are claimed (req_claim high while req_valid) and use romcs_n. 0x000E0000 and 0xFF000000 are not claimed. All strobes and chip selects are high (inactive) and req_ready is low.
- R2: cfg_wdata bit 0 opens 0xFF000000-0xFFFFFFFF and bit 1 opens 0x000E0000-0x000FFFFF, both as boot windows.
- R3: A request outside every enabled window keeps req_claim low, never asserts a strobe or chip select, and never raises req_ready.
- R4: In a claimed bus cycle, the chip select and the read or write strobe stay low for exactly WAIT_CLKS clocks. isa_addr carries the low 24 address bits. req_ready pulses for one clock, two clocks after the last strobe clock, and never while a strobe is active.
- R5: The ROM width is 16 bits when strap_w16 is high during reset and 8 bits otherwise. cfg_wdata bit 4 then sets it (1 = 16-bit).
- R6: In 8-bit mode, req_be = 2'b11 runs two byte cycles: first the even address, then the odd address, with one idle clock between them. A single-byte enable runs one cycle at that byte's address. Read data uses byte lane [7:0] of isa_din. Bytes that are not enabled read as zero in req_rdata, and isa_bhe_n stays high.
- R7: In 16-bit mode, any request runs a single cycle at the even address. isa_bhe_n is low exactly when req_be[1] is set, and req_rdata returns isa_din masked by the byte enables.
- R8: With cfg_wdata bit 3 clear, a write to a window is claimed and answered with req_ready on the clock after acceptance, with no strobe and no chip select.
- R9: With cfg_wdata bit 3 set, a write drives memw_n, wr_n and the chip select low, keeps memr_n high, and drives isa_dout with isa_doe high. In 8-bit mode the active byte goes out on lane [7:0].
- R10: cfg_wdata bit 2 opens 0x000C8000-0x000DFFFF as an expansion window that uses optcs_n and never romcs_n. The two chip selects are never low together. With the bit clear, that range is not claimed.
- R11: A configuration write takes effect only while no bus cycle is in progress. A cycle that is already running finishes with the settings it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strap_w16 | input | 1 | Width strap sampled during reset (1 = 16-bit ROM) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 5 | Configuration value: [0] 16 MB top window, [1] 128 KB low window, [2] expansion window, [3] ROM write enable, [4] 16-bit width |
| req_valid | input | 1 | Host request valid, held until req_ready |
| req_addr | input | 32 | Host physical address (bit 0 ignored) |
| req_write | input | 1 | Host request is a write |
| req_be | input | 2 | Host byte enables, nonzero |
| req_wdata | input | 16 | Host write data |
| req_claim | output | 1 | Request falls in an enabled window |
| req_ready | output | 1 | One-clock completion pulse |
| req_rdata | output | 16 | Read data, valid with req_ready |
| romcs_n | output | 1 | Boot ROM chip select, active low |
| optcs_n | output | 1 | Expansion ROM chip select, active low |
| memr_n | output | 1 | Memory read strobe, active low |
| memw_n | output | 1 | Memory write strobe, active low |
| wr_n | output | 1 | Device write strobe, active low |
| isa_addr | output | ISA_AW | ROM bus address |
| isa_bhe_n | output | 1 | High byte lane enable, active low |
| isa_dout | output | 16 | ROM bus write data |
| isa_doe | output | 1 | Write data drive enable |
| isa_din | input | 16 | ROM bus read data |

## Verification
The assertions assume a well-behaved host. It keeps req_valid and the request fields stable until req_ready, drops req_valid on the clock that follows req_ready, sends only even addresses, and never sends an all-zero byte enable. The bench drives requests only through one task that follows this protocol. It draws byte enables from the three nonzero codes and clears address bit 0 on every random address. The bench issues configuration writes while the bus is busy only in the one directed case that checks deferral.

// File: rtl/brd_pkg.sv
`timescale 1ns/1ps
package brd_pkg;

  localparam int HOST_AW = 32;
  localparam int DW      = 16;
  localparam int CFG_W   = 5;

  // bit 4 width16, bit 3 write enable, bit 2 expansion window, bit 1 low wide, bit 0 top wide
  typedef struct packed {
    logic w16;
    logic rom_we;
    logic opt_en;
    logic low_wide;
    logic top_wide;
  } brd_cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_STRB, S_GAP, S_DONE} seq_st_t;

  function automatic logic boot_hit(input logic [HOST_AW-1:0] a, input brd_cfg_t c);
    logic low64, low128, top256, top16m;
    low64  = (a[31:16] == 16'h000F);
    low128 = c.low_wide && (a[31:17] == 15'h0007);
    top256 = (a[31:18] == 14'h3FFF);
    top16m = c.top_wide && (a[31:24] == 8'hFF);
    return low64 || low128 || top256 || top16m;
  endfunction

  // 32 KB granules 0x19..0x1B of the first megabyte
  function automatic logic opt_hit(input logic [HOST_AW-1:0] a, input brd_cfg_t c);
    return c.opt_en && (a[31:20] == 12'h000) &&
           (a[19:15] >= 5'h19) && (a[19:15] <= 5'h1B);
  endfunction

  function automatic logic [DW-1:0] be_mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

endpackage

// File: rtl/brd_cfg.sv
`timescale 1ns/1ps
module brd_cfg
  import brd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strap_w16,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             apply_ok,
  output brd_cfg_t         cfg_live
);

  logic             pend_v;
  logic [CFG_W-1:0] pend_d;
  logic             apply_now;

  assign apply_now = pend_v && apply_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_live <= brd_cfg_t'({strap_w16, 4'b0000});
      pend_v   <= 1'b0;
      pend_d   <= '0;
    end else begin
      if (cfg_we) begin
        pend_d <= cfg_wdata;
        pend_v <= 1'b1;
      end else if (apply_now) begin
        pend_v <= 1'b0;
      end
      if (apply_now) cfg_live <= brd_cfg_t'(pend_d);
    end
  end

  // R11: live settings never move while the sequencer is busy
  p_apply_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ok |=> $stable(cfg_live));

endmodule

// File: rtl/brd_decode.sv
`timescale 1ns/1ps
module brd_decode
  import brd_pkg::*;
(
  input  logic [HOST_AW-1:0] addr,
  input  brd_cfg_t           cfg,
  output logic               hit_boot,
  output logic               hit_opt
);

  assign hit_boot = boot_hit(addr, cfg);
  assign hit_opt  = opt_hit(addr, cfg);

  // R10: the expansion range and the boot windows are disjoint
  always_comb begin
    a_disjoint_r10: assert (!(hit_boot && hit_opt));
  end

endmodule

// File: rtl/brd_isa_seq.sv
`timescale 1ns/1ps
module brd_isa_seq
  import brd_pkg::*;
#(
  parameter int WAIT_CLKS = 3,
  parameter int ISA_AW    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ISA_AW-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [DW-1:0]     req_wdata,
  input  logic              start_opt,
  input  logic              cfg_w16,
  input  logic              cfg_rom_we,
  input  logic [DW-1:0]     isa_din,
  output logic              idle,
  output logic              strb,
  output logic              wr_cyc,
  output logic              sel_opt,
  output logic [ISA_AW-1:0] isa_addr,
  output logic              isa_bhe_n,
  output logic [DW-1:0]     isa_dout,
  output logic              isa_doe,
  output logic              ready,
  output logic [DW-1:0]     rdata
);

  localparam int CW = $clog2(WAIT_CLKS + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(WAIT_CLKS - 1);

  seq_st_t         st;
  logic [CW-1:0]   cnt;
  logic [ISA_AW-2:0] base_q;
  logic            wr_q, w16_q, opt_q, hi_q, more_q;
  logic [1:0]      be_q;
  logic [DW-1:0]   wd_q, rd_q;
  logic            last_clk;
  logic            blocked;

  assign blocked  = req_write && !cfg_rom_we;
  assign last_clk = (st == S_STRB) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      base_q <= '0;
      wr_q   <= 1'b0;
      w16_q  <= 1'b0;
      opt_q  <= 1'b0;
      hi_q   <= 1'b0;
      more_q <= 1'b0;
      be_q   <= '0;
      wd_q   <= '0;
      rd_q   <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          base_q <= req_addr[ISA_AW-1:1];
          wr_q   <= req_write;
          w16_q  <= cfg_w16;
          opt_q  <= start_opt;
          be_q   <= req_be;
          wd_q   <= req_wdata;
          rd_q   <= '0;
          hi_q   <= !cfg_w16 && !req_be[0];
          more_q <= !cfg_w16 && (req_be == 2'b11);
          cnt    <= CNT_LOAD;
          st     <= blocked ? S_DONE : S_STRB;
        end
        S_STRB: begin
          if (cnt == '0) begin
            if (!wr_q) begin
              if (w16_q)     rd_q       <= isa_din & be_mask(be_q);
              else if (hi_q) rd_q[15:8] <= isa_din[7:0];
              else           rd_q[7:0]  <= isa_din[7:0];
            end
            st <= S_GAP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_GAP: begin
          if (more_q) begin
            more_q <= 1'b0;
            hi_q   <= 1'b1;
            cnt    <= CNT_LOAD;
            st     <= S_STRB;
          end else begin
            st <= S_DONE;
          end
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign idle      = (st == S_IDLE);
  assign strb      = (st == S_STRB);
  assign ready     = (st == S_DONE);
  assign wr_cyc    = wr_q;
  assign sel_opt   = opt_q;
  assign isa_addr  = {base_q, w16_q ? 1'b0 : hi_q};
  assign isa_bhe_n = !(w16_q && be_q[1]);
  assign isa_dout  = w16_q ? wd_q : {8'h00, hi_q ? wd_q[15:8] : wd_q[7:0]};
  assign isa_doe   = strb && wr_q;
  assign rdata     = rd_q;

  // observation counters for the timing checks
  logic [CW-1:0] run_len;
  logic          strb_prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len   <= '0;
      strb_prev <= 1'b0;
    end else begin
      run_len   <= strb ? run_len + 1'b1 : '0;
      strb_prev <= strb;
    end
  end

  p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_prev && !strb) |-> (run_len == CW'(WAIT_CLKS)));
  p_ready_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !strb);
  p_ready_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);
  p_write_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && req_write && !cfg_rom_we) |=> (ready && !strb));
  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb && !w16_q) |-> isa_bhe_n);
  p_last_clk_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_clk |=> !strb);

endmodule

// File: rtl/boot_rom_decoder.sv
`timescale 1ns/1ps
module boot_rom_decoder
  import brd_pkg::*;
#(
  parameter int WAIT_CLKS = 3,
  parameter int ISA_AW    = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_w16,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_be,
  input  logic [15:0]       req_wdata,
  output logic              req_claim,
  output logic              req_ready,
  output logic [15:0]       req_rdata,
  output logic              romcs_n,
  output logic              optcs_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              wr_n,
  output logic [ISA_AW-1:0] isa_addr,
  output logic              isa_bhe_n,
  output logic [15:0]       isa_dout,
  output logic              isa_doe,
  input  logic [15:0]       isa_din
);

  brd_cfg_t cfg_live;
  logic     hit_boot, hit_opt, any_hit;
  logic     seq_idle, strb, wr_cyc, sel_opt, start;

  brd_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_w16 (strap_w16),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .apply_ok  (seq_idle),
    .cfg_live  (cfg_live)
  );

  brd_decode u_dec (
    .addr     (req_addr),
    .cfg      (cfg_live),
    .hit_boot (hit_boot),
    .hit_opt  (hit_opt)
  );

  assign any_hit   = hit_boot || hit_opt;
  assign req_claim = req_valid && any_hit;
  assign start     = req_claim && seq_idle;

  brd_isa_seq #(.WAIT_CLKS(WAIT_CLKS), .ISA_AW(ISA_AW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .req_addr   (req_addr[ISA_AW-1:0]),
    .req_write  (req_write),
    .req_be     (req_be),
    .req_wdata  (req_wdata),
    .start_opt  (hit_opt),
    .cfg_w16    (cfg_live.w16),
    .cfg_rom_we (cfg_live.rom_we),
    .isa_din    (isa_din),
    .idle       (seq_idle),
    .strb       (strb),
    .wr_cyc     (wr_cyc),
    .sel_opt    (sel_opt),
    .isa_addr   (isa_addr),
    .isa_bhe_n  (isa_bhe_n),
    .isa_dout   (isa_dout),
    .isa_doe    (isa_doe),
    .ready      (req_ready),
    .rdata      (req_rdata)
  );

  assign romcs_n = !(strb && !sel_opt);
  assign optcs_n = !(strb && sel_opt);
  assign memr_n  = !(strb && !wr_cyc);
  assign memw_n  = !(strb && wr_cyc);
  assign wr_n    = !(strb && wr_cyc);

  p_cs_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~romcs_n, ~optcs_n}));
  p_no_hit_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !(req_valid && any_hit)) |=> (romcs_n && optcs_n && memr_n && memw_n));
  p_write_needs_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !memw_n |-> (cfg_live.rom_we && !wr_n && memr_n && isa_doe));
  p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_idle && $past(!seq_idle)) |-> $stable(cfg_live));

endmodule

// File: tb/sim_boot_rom_decoder.sv
`timescale 1ns/1ps
module sim_boot_rom_decoder;

  localparam int W  = 3;
  localparam int AW = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_w16 = 1'b0;
  logic cfg_we = 1'b0;
  logic [4:0] cfg_wdata = '0;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic req_write = 1'b0;
  logic [1:0] req_be = 2'b11;
  logic [15:0] req_wdata = '0;
  logic req_claim, req_ready;
  logic [15:0] req_rdata;
  logic romcs_n, optcs_n, memr_n, memw_n, wr_n, isa_bhe_n, isa_doe;
  logic [AW-1:0] isa_addr;
  logic [15:0] isa_dout, isa_din;

  int n_chk = 0;
  int n_fail = 0;

  // bench model of the settings
  logic m_top = 0, m_low = 0, m_opt = 0, m_we = 0, m_w16 = 0;

  always #2.5 clk = ~clk;

  boot_rom_decoder #(.WAIT_CLKS(W), .ISA_AW(AW)) u0 (.*);

  function automatic logic [7:0] f_rom(input logic [AW-1:0] a);
    return {a[3:0], a[7:4]} ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  always_comb
    isa_din = m_w16 ? {f_rom(isa_addr | 24'h1), f_rom(isa_addr & ~24'h1)}
                    : {8'h00, f_rom(isa_addr)};

  function automatic bit f_boot(input logic [31:0] a);
    return (a >= 32'h000F0000 && a <= 32'h000FFFFF) ||
           (m_low && a >= 32'h000E0000 && a <= 32'h000FFFFF) ||
           (a >= 32'hFFFC0000) || (m_top && a >= 32'hFF000000);
  endfunction

  function automatic bit f_opt(input logic [31:0] a);
    return m_opt && a >= 32'h000C8000 && a <= 32'h000DFFFF;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_model(input logic [4:0] v);
    {m_w16, m_we, m_opt, m_low, m_top} = v;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; strap_w16 = strap; req_valid = 1'b0; cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    set_model({strap, 4'b0000});
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [4:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    set_model(v);
  endtask

  task automatic access(input logic [31:0] a, input bit wr, input logic [1:0] be,
                        input logic [15:0] wd, input string req,
                        input bit mid, input logic [4:0] mid_val);
    bit exp_claim, exp_opt, strobe, prev, got, bad_cs, bad_sig, mid_done, mid_clr;
    int nb, exp_nb, last_i, ready_i;
    int lens[2], starts[2], ends_[2];
    logic [AW-1:0] addrs[2];
    logic bhes[2];
    logic [15:0] douts[2];
    logic [15:0] rd, exp_rd;
    exp_claim = f_boot(a) || f_opt(a);
    exp_opt = f_opt(a);
    nb = 0; prev = 0; got = 0; bad_cs = 0; bad_sig = 0; mid_done = 0; mid_clr = 0;
    last_i = -1; ready_i = -1; rd = '0;
    lens = '{0, 0}; starts = '{0, 0}; ends_ = '{0, 0};
    addrs = '{'0, '0}; bhes = '{0, 0}; douts = '{'0, '0};
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_be = be; req_wdata = wd;
    #1;
    chk(req_claim == exp_claim, exp_claim ? req : "R3", "claim", 32'(req_claim), 32'(exp_claim));
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mid_clr) begin cfg_we = 1'b0; mid_clr = 0; end
      strobe = !memr_n || !memw_n || !romcs_n || !optcs_n;
      if (strobe) begin
        if (!prev) begin
          if (nb < 2) begin
            addrs[nb] = isa_addr; bhes[nb] = isa_bhe_n; douts[nb] = isa_dout; starts[nb] = i;
          end
          nb++;
        end
        if (nb <= 2) begin lens[nb-1]++; ends_[nb-1] = i; end
        last_i = i;
        if (exp_opt ? !(optcs_n == 0 && romcs_n == 1) : !(romcs_n == 0 && optcs_n == 1)) bad_cs = 1;
        if (wr ? !(memw_n == 0 && wr_n == 0 && memr_n == 1 && isa_doe)
               : !(memr_n == 0 && memw_n == 1 && wr_n == 1 && !isa_doe)) bad_sig = 1;
        if (mid && !mid_done) begin
          cfg_we = 1'b1; cfg_wdata = mid_val; mid_done = 1; mid_clr = 1;
        end
      end
      if (req_ready) begin
        if (strobe) bad_sig = 1;
        rd = req_rdata; got = 1; ready_i = i;
        req_valid = 1'b0;
        break;
      end
      if (!exp_claim && i == 6) begin req_valid = 1'b0; break; end
      prev = strobe;
    end
    if (mid_clr) cfg_we = 1'b0;
    if (!exp_claim) begin
      chk(nb == 0, "R3", "bus activity on unclaimed", 32'(nb), 0);
      chk(!got, "R3", "ready on unclaimed", 32'(got), 0);
    end else begin
      if (wr && !m_we) exp_nb = 0;
      else if (m_w16) exp_nb = 1;
      else exp_nb = (be == 2'b11) ? 2 : 1;
      chk(got, req, "ready seen", 32'(got), 1);
      chk(nb == exp_nb, req, "burst count", 32'(nb), 32'(exp_nb));
      chk(!bad_cs, exp_opt ? "R10" : req, "chip select", 32'(bad_cs), 0);
      chk(!bad_sig, wr ? "R9" : "R4", "strobe signals", 32'(bad_sig), 0);
      if (exp_nb == 0)
        chk(ready_i == 0, "R8", "blocked write ready delay", 32'(ready_i), 0);
      else
        chk(ready_i - last_i == 2, "R4", "ready after strobe", 32'(ready_i - last_i), 2);
      if (exp_nb == 2)
        chk(starts[1] - ends_[0] == 2, "R6", "gap between bytes", 32'(starts[1] - ends_[0]), 2);
      for (int k = 0; k < exp_nb && k < nb; k++) begin
        logic idx;
        logic [AW-1:0] ea;
        idx = m_w16 ? 1'b0 : ((be == 2'b10) ? 1'b1 : 1'(k));
        ea = {a[AW-1:1], idx};
        chk(lens[k] == W, "R4", "strobe length", 32'(lens[k]), W);
        chk(addrs[k] == ea, m_w16 ? "R7" : "R6", "isa address", 32'(addrs[k]), 32'(ea));
        chk(bhes[k] == (m_w16 ? !be[1] : 1'b1), m_w16 ? "R7" : "R6", "bhe",
            32'(bhes[k]), 32'(m_w16 ? !be[1] : 1'b1));
        if (wr) begin
          logic [15:0] ed;
          ed = m_w16 ? wd : {8'h00, idx ? wd[15:8] : wd[7:0]};
          chk(douts[k] == ed, "R9", "write data", 32'(douts[k]), 32'(ed));
        end
      end
      if (!wr) begin
        exp_rd = {be[1] ? f_rom({a[AW-1:1], 1'b1}) : 8'h00,
                  be[0] ? f_rom({a[AW-1:1], 1'b0}) : 8'h00};
        chk(rd == exp_rd, m_w16 ? "R7" : "R6", "read data", 32'(rd), 32'(exp_rd));
      end
    end
    if (mid) begin
      repeat (2) @(negedge clk);
      set_model(mid_val);
    end
    @(negedge clk);
  endtask

  task automatic rd_(input logic [31:0] a, input logic [1:0] be, input string req);
    access(a, 1'b0, be, 16'h0000, req, 1'b0, 5'b0);
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] r;
    r = $urandom;
    case ($urandom % 8)
      0: return 32'h000F0000 + (r & 32'h0000FFFE);
      1: return 32'h000E0000 + (r & 32'h0001FFFE);
      2: return 32'hFFFC0000 + (r & 32'h0003FFFE);
      3: return 32'hFF000000 + (r & 32'h00FFFFFE);
      4: return 32'h000C8000 + ((r % 32'h18000) & ~32'h1);
      5: return r & ~32'h1;
      6: return 32'h000C0000 + (r & 32'h0000FFFE);
      default: return (r[0] ? 32'hFFFBFFFE : 32'h000C7FFE);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    do_reset(1'b0);
    // R1 idle state after reset
    chk(romcs_n && optcs_n && memr_n && memw_n && wr_n, "R1", "bus idle",
        {27'b0, romcs_n, optcs_n, memr_n, memw_n, wr_n}, 32'h1F);
    chk(!req_ready && !req_claim, "R1", "ready/claim low", {30'b0, req_ready, req_claim}, 0);
    // R1 reset windows
    rd_(32'h000FFFF0, 2'b11, "R1");
    rd_(32'hFFFFFFF0, 2'b01, "R1");
    rd_(32'hFFFC0000, 2'b10, "R1");
    rd_(32'h000E0000, 2'b11, "R1");
    rd_(32'hFF000000, 2'b11, "R1");
    // R3 addresses outside
    rd_(32'h00001000, 2'b11, "R3");
    rd_(32'hFFF00000, 2'b11, "R3");
    // R10 expansion window closed
    rd_(32'h000C8000, 2'b11, "R10");
    // R2 widened windows
    cfg_write(5'b00011);
    rd_(32'h000E1234, 2'b11, "R2");
    rd_(32'hFF123456, 2'b10, "R2");
    // R10 expansion window open, boundaries
    cfg_write(5'b00111);
    rd_(32'h000C8000, 2'b11, "R10");
    rd_(32'h000DFFFE, 2'b01, "R10");
    rd_(32'h000C7FFE, 2'b11, "R10");
    rd_(32'h000E0000, 2'b11, "R10");
    // R8 blocked write
    access(32'h000F0000, 1'b1, 2'b11, 16'hA55A, "R8", 1'b0, 5'b0);
    access(32'h000C9000, 1'b1, 2'b01, 16'h1234, "R8", 1'b0, 5'b0);
    // R9 enabled writes, 8-bit
    cfg_write(5'b01111);
    access(32'h000F0100, 1'b1, 2'b11, 16'hBEEF, "R9", 1'b0, 5'b0);
    access(32'h000D0002, 1'b1, 2'b10, 16'hC3D4, "R9", 1'b0, 5'b0);
    // R5 software width override, R7 16-bit behaviour
    cfg_write(5'b11111);
    rd_(32'h000F4444, 2'b11, "R5");
    rd_(32'h000F4446, 2'b10, "R7");
    rd_(32'hFFFE0008, 2'b01, "R7");
    access(32'h000F2000, 1'b1, 2'b11, 16'h9876, "R9", 1'b0, 5'b0);
    access(32'h000F2002, 1'b1, 2'b01, 16'h4321, "R9", 1'b0, 5'b0);
    // R11 config written mid-cycle is deferred
    access(32'h000F3000, 1'b0, 2'b11, 16'h0, "R11", 1'b1, 5'b01111);
    rd_(32'h000F3000, 2'b11, "R11");
    // R5 strap selects 16-bit at reset
    do_reset(1'b1);
    rd_(32'h000F8888, 2'b11, "R5");
    do_reset(1'b0);
    rd_(32'h000F8888, 2'b11, "R5");
    // random phase
    for (int n = 0; n < 300; n++) begin
      logic [1:0] be;
      if ($urandom % 25 == 0) cfg_write(5'($urandom));
      be = 2'($urandom % 3 + 1);
      access(rand_addr(), ($urandom % 4) == 0, be, 16'($urandom), "R4", 1'b0, 5'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule